// File: doc/BRIEF.md
# Output Pad Channel Mapper

This block sits between a set of serialized display data channels and a row of output pads. Each pad owns one control word that sets its source channel, an optional half-period delay, its polarity, its drive style and its output enable. Twice as many channels as pads enter the block. A pad in differential style takes its data from channel i or i-1. A pad in single-ended style takes it from 2i or 2i-1, and a second N-side pin then carries channel 2i+1 or 2i under its own selector, delay and polarity. Each selector can also pick the bit clock itself or a constant zero.

The bit clock also clocks the configuration write port. Software-side logic writes one pad's word per cycle through a simple write strobe. The half-period delay comes from a falling-edge flop, so a delayed output shows the value the channel had at the previous falling edge of the bit clock.

Top module: `pad_chan_mapper`

## Requirements
- R1: While reset is held, and after it until the first write, every pad output, N-side output and output enable is 0.
- R2: With wr_en high at a rising clock edge, wr_data is loaded into the control word of pad wr_addr. The change appears at the outputs right after that edge, and the words of other pads keep their values.
- R3: Differential style (bit 4 = 0): selector bits 18:17 choose channel i for 00, channel i-1 for 01, the bit clock for 10 and constant 0 for 11. On pad 0, code 01 gives constant 0.
- R4: Single-ended style (bit 4 = 1): selector bits 18:17 choose channel 2i for 00, channel 2i-1 for 01, the bit clock for 10 and constant 0 for 11. On pad 0, code 01 gives constant 0.
- R5: Single-ended style: N-side selector bits 20:19 choose channel 2i+1 for 00, channel 2i for 01, the bit clock for 10 and constant 0 for 11.
- R6: Polarity bit 5 inverts the pad output when it is 1 in single-ended style. In differential style the bit inverts when it is 0 and passes the value unchanged when it is 1.
- R7: Single-ended style: N-side polarity bit 6 inverts the N-side output when it is 1.
- R8: Delay bit 13 makes the pad output show the selected source as it was at the previous falling clock edge. In single-ended style, N-side delay bit 14 does the same for the N-side output.
- R9: Differential style: the N-side output is the complement of the pad output, and N-side fields (bits 20:19, 14, 6) have no effect.
- R10: Output-enable bit 7 = 0 forces the pad and N-side outputs to 0 and drops both enables. Bit 7 = 1 raises both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; also clocks the write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | ADDR_W | Pad index of the write |
| wr_data | input | 32 | Control word to load |
| chan_in | input | 2*NUM_PADS | Serialized data channels |
| pad_p | output | NUM_PADS | Pad (P-side) output data |
| pad_n | output | NUM_PADS | N-side output data |
| pad_oe_p | output | NUM_PADS | Pad output enable |
| pad_oe_n | output | NUM_PADS | N-side output enable |

## Verification
The half-period delay and a change of channel data can fall in the same bit-clock cycle. The stimulus drives one channel value before a falling edge and a different one just after it, then samples while the clock is low. At that moment an undelayed path must already show the new value and a delayed path must still show the old one. Pad and N-side paths are given opposite delay settings in the same cycle, so a swapped or missing delay shows up on one of the two pins.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   localparam int unsigned CFG_W     = 32;
   localparam int unsigned F_NSEL_LO = 19;
   localparam int unsigned F_SEL_LO  = 17;
   localparam int unsigned F_NDLY    = 14;
   localparam int unsigned F_DLY     = 13;
   localparam int unsigned F_OE      = 7;
   localparam int unsigned F_NPOL    = 6;
   localparam int unsigned F_POL     = 5;
   localparam int unsigned F_MODE    = 4;

   typedef enum logic [1:0] {
      SRC_PRIMARY  = 2'b00,
      SRC_NEIGHBOR = 2'b01,
      SRC_BITCLK   = 2'b10,
      SRC_ZERO     = 2'b11
   } src_sel_e;

   typedef enum logic {
      DRV_DIFF   = 1'b0,
      DRV_SINGLE = 1'b1
   } drv_mode_e;

   typedef struct packed {
      src_sel_e  nsel;
      src_sel_e  sel;
      logic      ndly;
      logic      dly;
      logic      oe;
      logic      npol;
      logic      pol;
      drv_mode_e mode;
   } pad_cfg_t;

   localparam pad_cfg_t CFG_RESET = '{
      nsel: SRC_PRIMARY,
      sel:  SRC_PRIMARY,
      ndly: 1'b0,
      dly:  1'b0,
      oe:   1'b0,
      npol: 1'b0,
      pol:  1'b0,
      mode: DRV_DIFF
   };

   // Bits of the control word that carry a field.
   function automatic logic [CFG_W-1:0] used_mask();
      logic [CFG_W-1:0] m;
      m = '0;
      m[F_NSEL_LO+1:F_NSEL_LO] = 2'b11;
      m[F_SEL_LO+1:F_SEL_LO]   = 2'b11;
      m[F_NDLY] = 1'b1;
      m[F_DLY]  = 1'b1;
      m[F_OE]   = 1'b1;
      m[F_NPOL] = 1'b1;
      m[F_POL]  = 1'b1;
      m[F_MODE] = 1'b1;
      return m;
   endfunction

   function automatic pad_cfg_t decode_word(input logic [CFG_W-1:0] w);
      pad_cfg_t c;
      c.nsel = src_sel_e'(w[F_NSEL_LO+1:F_NSEL_LO]);
      c.sel  = src_sel_e'(w[F_SEL_LO+1:F_SEL_LO]);
      c.ndly = w[F_NDLY];
      c.dly  = w[F_DLY];
      c.oe   = w[F_OE];
      c.npol = w[F_NPOL];
      c.pol  = w[F_POL];
      c.mode = drv_mode_e'(w[F_MODE]);
      return c;
   endfunction

   // One source selector: primary, neighbour, bit clock or zero.
   function automatic logic pick_src(input src_sel_e s, input logic pri,
                                     input logic nb, input logic bclk);
      logic r;
      case (s)
         SRC_PRIMARY:  r = pri;
         SRC_NEIGHBOR: r = nb;
         SRC_BITCLK:   r = bclk;
         default:      r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcm_cfg_regs.sv
module pcm_cfg_regs
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_PADS = 4,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CFG_W-1:0] wr_data,
   output pad_cfg_t         cfg_q [NUM_PADS]
);

   localparam logic [CFG_W-1:0] FIELD_MASK = used_mask();

   pad_cfg_t next_cfg;
   logic     unused_wr_bits;

   assign next_cfg       = decode_word(wr_data);
   assign unused_wr_bits = ^(wr_data & ~FIELD_MASK);

   initial begin : chk_layout
      assert (CFG_W > F_NSEL_LO + 1)
         else $fatal(1, "control word too narrow for its fields");
      assert ((2 ** ADDR_W) >= NUM_PADS)
         else $fatal(1, "address width cannot reach every pad");
   end

   for (genvar g = 0; g < NUM_PADS; g++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= CFG_RESET;
         end else if (hit) begin
            cfg_q[g] <= next_cfg;
         end
      end
   end

endmodule

// File: rtl/pcm_src_mux.sv
module pcm_src_mux
   import pcm_pkg::*;
(
   input  logic      bit_clk,
   input  drv_mode_e mode,
   input  src_sel_e  sel,
   input  src_sel_e  nsel,
   input  logic      diff_pri,
   input  logic      diff_nb,
   input  logic      se_pri,
   input  logic      se_nb,
   input  logic      se_npri,
   output logic      p_raw,
   output logic      n_raw
);

   logic pri_c;
   logic nb_c;

   // Channel window follows the drive style: i / i-1 or 2i / 2i-1.
   always_comb begin
      if (mode == DRV_SINGLE) begin
         pri_c = se_pri;
         nb_c  = se_nb;
      end else begin
         pri_c = diff_pri;
         nb_c  = diff_nb;
      end
   end

   assign p_raw = pick_src(sel, pri_c, nb_c, bit_clk);
   // N side: 2i+1 as primary, 2i as neighbour.
   assign n_raw = pick_src(nsel, se_npri, se_pri, bit_clk);

endmodule

// File: rtl/pcm_half_delay.sv
module pcm_half_delay (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic en,
   output logic q
);

   logic held_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else begin
         held_q <= d;
      end
   end

   assign q = en ? held_q : d;

endmodule

// File: rtl/pcm_pad_lane.sv
module pcm_pad_lane
   import pcm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pad_cfg_t cfg,
   input  logic     diff_pri,
   input  logic     diff_nb,
   input  logic     se_pri,
   input  logic     se_nb,
   input  logic     se_npri,
   output logic     pad_p,
   output logic     pad_n,
   output logic     oe_p,
   output logic     oe_n
);

   logic single;
   logic p_raw, n_raw;
   logic p_dly, n_dly;
   logic p_inv;
   logic p_val, n_val;

   assign single = (cfg.mode == DRV_SINGLE);

   pcm_src_mux u_mux (
      .bit_clk  (clk),
      .mode     (cfg.mode),
      .sel      (cfg.sel),
      .nsel     (cfg.nsel),
      .diff_pri (diff_pri),
      .diff_nb  (diff_nb),
      .se_pri   (se_pri),
      .se_nb    (se_nb),
      .se_npri  (se_npri),
      .p_raw    (p_raw),
      .n_raw    (n_raw)
   );

   pcm_half_delay u_dly_p (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (p_raw),
      .en    (cfg.dly),
      .q     (p_dly)
   );

   pcm_half_delay u_dly_n (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (n_raw),
      .en    (cfg.ndly & single),
      .q     (n_dly)
   );

   // Polarity sense flips with drive style.
   assign p_inv = single ? cfg.pol : ~cfg.pol;
   assign p_val = p_dly ^ p_inv;
   assign n_val = single ? (n_dly ^ cfg.npol) : ~p_val;

   assign pad_p = cfg.oe & p_val;
   assign pad_n = cfg.oe & n_val;
   assign oe_p  = cfg.oe;
   assign oe_n  = cfg.oe;

endmodule

// File: rtl/pad_chan_mapper.sv
module pad_chan_mapper
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_PADS = 4,
   localparam int unsigned NUM_CHANS = 2 * NUM_PADS,
   localparam int unsigned ADDR_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [CFG_W-1:0]     wr_data,
   input  logic [NUM_CHANS-1:0] chan_in,
   output logic [NUM_PADS-1:0]  pad_p,
   output logic [NUM_PADS-1:0]  pad_n,
   output logic [NUM_PADS-1:0]  pad_oe_p,
   output logic [NUM_PADS-1:0]  pad_oe_n
);

   pad_cfg_t cfg_q [NUM_PADS];

   initial begin : chk_params
      assert (NUM_PADS >= 1) else $fatal(1, "at least one pad required");
   end

   pcm_cfg_regs #(
      .NUM_PADS (NUM_PADS),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg_q   (cfg_q)
   );

   for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
      logic nb_diff;
      logic nb_se;

      if (g == 0) begin : g_edge
         // No channel below the first pad: neighbour reads as zero.
         assign nb_diff = 1'b0;
         assign nb_se   = 1'b0;
      end else begin : g_inner
         assign nb_diff = chan_in[g-1];
         assign nb_se   = chan_in[2*g-1];
      end

      pcm_pad_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cfg_q[g]),
         .diff_pri (chan_in[g]),
         .diff_nb  (nb_diff),
         .se_pri   (chan_in[2*g]),
         .se_nb    (nb_se),
         .se_npri  (chan_in[2*g+1]),
         .pad_p    (pad_p[g]),
         .pad_n    (pad_n[g]),
         .oe_p     (pad_oe_p[g]),
         .oe_n     (pad_oe_n[g])
      );
   end

endmodule

// File: rtl/pcm_checker.sv
module pcm_checker
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_PADS = 4,
   parameter int unsigned ADDR_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic                wr_oe,
   input pad_cfg_t            cfg [NUM_PADS],
   input logic [NUM_PADS-1:0] pad_p,
   input logic [NUM_PADS-1:0] pad_n,
   input logic [NUM_PADS-1:0] pad_oe_p,
   input logic [NUM_PADS-1:0] pad_oe_n
);

   logic [NUM_PADS-1:0] unused_cfg_bits;

   for (genvar g = 0; g < NUM_PADS; g++) begin : g_chk
      assign unused_cfg_bits[g] = ^cfg[g];

      AST_OE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !pad_oe_p[g] |-> (!pad_p[g] && !pad_n[g] && !pad_oe_n[g])); // R10

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(g)) |=> (pad_oe_p[g] == $past(wr_oe))); // R2

      AST_DIFF_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_oe_p[g] && cfg[g].mode == DRV_DIFF) |-> (pad_n[g] != pad_p[g])); // R9

      AST_ZERO_SOURCE_POL: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg[g].oe && cfg[g].sel == SRC_ZERO && !cfg[g].dly)
         |-> (pad_p[g] == ((cfg[g].mode == DRV_SINGLE) ? cfg[g].pol : !cfg[g].pol))); // R6

      if (g == 0) begin : g_first
         AST_FIRST_PAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[0].oe && cfg[0].mode == DRV_DIFF && cfg[0].sel == SRC_NEIGHBOR && !cfg[0].dly)
            |-> (pad_p[0] == !cfg[0].pol)); // R3
      end
   end

endmodule

bind pad_chan_mapper pcm_checker #(
   .NUM_PADS (NUM_PADS),
   .ADDR_W   (ADDR_W)
) u_pcm_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_oe    (wr_data[pcm_pkg::F_OE]),
   .cfg      (cfg_q),
   .pad_p    (pad_p),
   .pad_n    (pad_n),
   .pad_oe_p (pad_oe_p),
   .pad_oe_n (pad_oe_n)
);

// File: tb/pad_chan_mapper_test.sv
`timescale 1ns/100ps
module pad_chan_mapper_test;

   localparam int NP = 4;
   localparam int NC = 2 * NP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [NC-1:0] chan_in = '1;
   logic [NP-1:0] pad_p, pad_n, pad_oe_p, pad_oe_n;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   pad_chan_mapper #(.NUM_PADS(NP)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .chan_in  (chan_in),
      .pad_p    (pad_p),
      .pad_n    (pad_n),
      .pad_oe_p (pad_oe_p),
      .pad_oe_n (pad_oe_n)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [1:0] pad;
      logic [1:0] nsel;
      logic [1:0] sel;
      logic       ndly;
      logic       dly;
      logic       oe;
      logic       npol;
      logic       pol;
      logic       mode;
      logic [7:0] a;    // channels before the falling edge
      logic [7:0] b;    // channels after it
      logic       ep;
      logic       en;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VEC [NVEC] = '{
      '{4'd3,  2'd1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h02, 1'b1, 1'b0}, // R3 ch i, R9
      '{4'd3,  2'd1, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01, 1'b1, 1'b0}, // R3 ch i-1
      '{4'd6,  2'd2, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0, 1'b1}, // R6 diff pol 0 inverts
      '{4'd3,  2'd0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b1}, // R3 pad 0 wrap
      '{4'd4,  2'd0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1}, // R4 pad 0 wrap, R5 ch 2i
      '{4'd4,  2'd1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04, 1'b1, 1'b0}, // R4 ch 2i, R5 ch 2i+1
      '{4'd7,  2'd1, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h02, 1'b0, 1'b1}, // R7 R6 R4 ch 2i-1
      '{4'd8,  2'd3, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h40, 8'h80, 1'b1, 1'b1}, // R8 P delayed, N not
      '{4'd8,  2'd3, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h40, 8'h80, 1'b0, 1'b0}, // R8 N delayed, P not
      '{4'd9,  2'd2, 2'b11, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h04, 8'h00, 1'b1, 1'b0}, // R9 N fields ignored, R8
      '{4'd3,  2'd2, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1}, // R3 bit clock, low
      '{4'd3,  2'd2, 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0}, // R3 const 0 inverted
      '{4'd10, 2'd1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0}, // R10 disabled
      '{4'd5,  2'd3, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1}  // R5 const 0 inverted
   };

   task automatic chk(input int req, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   function automatic logic [31:0] mk_word(input vec_t t);
      logic [31:0] w;
      w = 32'h0000_0003;            // filler in unused bits
      w[20:19] = t.nsel;
      w[18:17] = t.sel;
      w[14]    = t.ndly;
      w[13]    = t.dly;
      w[7]     = t.oe;
      w[6]     = t.npol;
      w[5]     = t.pol;
      w[4]     = t.mode;
      return w;
   endfunction

   task automatic write_cfg(input logic [1:0] pad, input logic [31:0] word);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = pad;
      wr_data = word;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      // R1: reset state with all channels high
      repeat (3) @(negedge clk);
      #1;
      chk(1, "pad_p in reset",    |pad_p,    1'b0);
      chk(1, "pad_n in reset",    |pad_n,    1'b0);
      chk(1, "pad_oe_p in reset", |pad_oe_p, 1'b0);
      chk(1, "pad_oe_n in reset", |pad_oe_n, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(1, "pad_p after reset",    |pad_p,    1'b0);
      chk(1, "pad_oe_p after reset", |pad_oe_p, 1'b0);

      for (int v = 0; v < NVEC; v++) begin
         vec_t t;
         t = VEC[v];
         write_cfg(t.pad, mk_word(t));
         #0.5 chan_in = t.a;
         @(negedge clk);
         #0.5 chan_in = t.b;
         #0.5;
         chk(int'(t.req), $sformatf("vector %0d pad_p", v), pad_p[t.pad], t.ep);
         chk(int'(t.req), $sformatf("vector %0d pad_n", v), pad_n[t.pad], t.en);
         chk(int'(t.req), $sformatf("vector %0d pad_oe_p", v), pad_oe_p[t.pad], t.oe);
         chk(int'(t.req), $sformatf("vector %0d pad_oe_n", v), pad_oe_n[t.pad], t.oe);
      end

      // R4: bit clock source seen while the clock is high, single-ended, no inversion
      write_cfg(2'd0, 32'h0004_0090);
      @(posedge clk);
      #1;
      chk(4, "bit clock high on pad 0", pad_p[0], 1'b1);
      @(negedge clk);
      #1;
      chk(4, "bit clock low on pad 0", pad_p[0], 1'b0);

      // R2: a write to one pad leaves the others as they were
      write_cfg(2'd2, 32'h0000_0000);
      #1;
      chk(2, "written pad 2 enable", pad_oe_p[2], 1'b0);
      chk(2, "pad 3 enable untouched", pad_oe_p[3], 1'b1);
      chk(2, "pad 0 enable untouched", pad_oe_p[0], 1'b1);

      // R10: enable drops and outputs clear when bit 7 is cleared
      write_cfg(2'd3, 32'h0000_0050);
      #1;
      chk(10, "pad 3 p with enable off", pad_p[3], 1'b0);
      chk(10, "pad 3 n with enable off", pad_n[3], 1'b0);
      chk(10, "pad 3 oe_n with enable off", pad_oe_n[3], 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule